// File: doc/BRIEF.md
# Charge Cycle Sequencer

This block steps a single-cell battery through a full charge cycle with no software involvement. A set of analog comparator flags tells it where the battery stands: below the pre-charge level, at the charge voltage, below the termination current, or below the recharge level. From these flags the block moves through a low-current conditioning phase, then a constant-current phase, then a constant-voltage phase. It ends the cycle when the current tapers off. Once the battery has sagged for long enough, it starts a new cycle on its own.

The block also drives two host-facing outputs. The first is an active-low status line that shows charging, blinks slowly on a fault, and can be muted. The second is an active-low interrupt that gives one fixed-width pulse whenever the phase changes. A 1 ms tick input provides the slow time base. Pulse widths are counted in core clock cycles.

Top module: `chg_seq_top`

## Requirements
- R1: While reset is held, `phase` is 0 (idle), `stat_n` is 1 and `int_n` is 1.
- R2: Charging needs both `en_bit` = 1 and `en_n` = 0. With no fault, any other combination drives `phase` to 0 (idle) on the next clock.
- R3: From idle with charging allowed, the next phase is 1 (conditioning) if `bat_pre` = 1, and 2 (constant current) otherwise. Conditioning moves to 2 on the clock after `bat_pre` falls.
- R4: Constant current (2) moves to constant voltage (3) on the clock after `at_vreg` = 1.
- R5: `cur_term` ends the cycle only in phase 3, which then moves to 4 (done). In phases 1 and 2, `cur_term` has no effect.
- R6: In done (4), the block requalifies as in R3 only after `bat_rechg` has been 1 on RECHG_MS consecutive ticks. A clock with `bat_rechg` = 0 restarts that count.
- R7: `fault` = 1 drives `phase` to 5 (fault) on the next clock from any phase. After `fault` clears, the block passes through idle (0) and then requalifies.
- R8: `temp_ok` = 0 suspends charging. `phase` goes to 0 (idle) and requalifies once `temp_ok` returns to 1.
- R9: With `stat_off` = 0, `stat_n` is 0 in phases 1, 2 and 3, and 1 in phases 0 and 4.
- R10: In phase 5, `stat_n` is 0 for the first BLINK_HALF_MS ticks after entry. It then alternates high and low every BLINK_HALF_MS ticks, which gives a 1 Hz blink at the default setting.
- R11: `stat_off` = 1 holds `stat_n` at 1 in every phase.
- R12: `int_n` goes to 0 in the same cycle that `phase` takes a new value and stays at 0 for exactly PULSE_CYC cycles. A further change during the pulse restarts the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (1.5 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| en_bit | input | 1 | Charge enable setting, active high |
| en_n | input | 1 | Charge enable pin, active low |
| temp_ok | input | 1 | Thermistor reading inside the allowed window |
| fault | input | 1 | Any protection fault present |
| stat_off | input | 1 | Mutes the status line |
| bat_pre | input | 1 | Battery below the pre-charge threshold |
| cur_term | input | 1 | Charge current below the termination level |
| bat_rechg | input | 1 | Battery below the recharge threshold |
| at_vreg | input | 1 | Battery has reached the charge voltage |
| phase | output | 3 | 0 idle, 1 conditioning, 2 CC, 3 CV, 4 done, 5 fault |
| stat_n | output | 1 | Status line, active low |
| int_n | output | 1 | Interrupt pulse, active low |

## Verification
The bench builds the block with RECHG_MS = 4, BLINK_HALF_MS = 3 and PULSE_CYC = 10, and issues a tick every five clocks. With these values the recharge deglitch fits in twenty cycles, a full blink period in thirty, and an interrupt pulse in ten. That makes an interrupted deglitch, several blink edges and pulse restarts from quickly repeated phase changes all cheap to reach. Several thousand random cycles then cover their interplay with faults and enable changes.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_CC    = 3'd2,
    PH_CV    = 3'd3,
    PH_DONE  = 3'd4,
    PH_FAULT = 3'd5
  } phase_e;

  // Phases in which current flows into the battery.
  function automatic logic is_charging(phase_e p);
    return (p == PH_PRE) || (p == PH_CC) || (p == PH_CV);
  endfunction

  // Entry decision for a fresh cycle.
  function automatic phase_e qualify(logic below_pre);
    return below_pre ? PH_PRE : PH_CC;
  endfunction

  // Last tick of a deglitch or half-period window.
  function automatic logic window_end(int unsigned count, int unsigned len);
    return count == len - 1;
  endfunction

endpackage

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_seq_pkg::*;
#(
  parameter int RECHG_MS = 20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   allow,
  input  logic   fault,
  input  logic   bat_pre,
  input  logic   cur_term,
  input  logic   at_vreg,
  input  logic   bat_rechg,
  output phase_e phase_q,
  output logic   phase_evt,
  output logic   rechg_go
);
  localparam int CW = $clog2(RECHG_MS + 1);

  logic [CW-1:0] rc_q;
  phase_e        phase_d;

  assign rechg_go = (phase_q == PH_DONE) && bat_rechg && tick &&
                    window_end(int'(rc_q), RECHG_MS);

  always_comb begin
    phase_d = phase_q;
    if (fault) begin
      phase_d = PH_FAULT;
    end else if (!allow) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:  phase_d = qualify(bat_pre);
        PH_PRE:   phase_d = qualify(bat_pre);
        PH_CC:    phase_d = at_vreg ? PH_CV : PH_CC;
        PH_CV:    phase_d = cur_term ? PH_DONE : PH_CV;
        PH_DONE:  phase_d = rechg_go ? qualify(bat_pre) : PH_DONE;
        PH_FAULT: phase_d = PH_IDLE;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  assign phase_evt = (phase_d != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      rc_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q != PH_DONE || !bat_rechg) begin
        rc_q <= '0;
      end else if (tick) begin
        rc_q <= rc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chg_blink.sv
module chg_blink
  import chg_seq_pkg::*;
#(
  parameter int HALF_MS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  output logic level
);
  localparam int BW = $clog2(HALF_MS + 1);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      level <= 1'b0;
    end else if (!active) begin
      cnt_q <= '0;
      level <= 1'b0;
    end else if (tick) begin
      if (window_end(int'(cnt_q), HALF_MS)) begin
        cnt_q <= '0;
        level <= ~level;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chg_intp.sv
module chg_intp #(
  parameter int PULSE_CYC = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic pulse_n
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (evt) begin
      left_q <= PW'(PULSE_CYC);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign pulse_n = (left_q == '0);
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_seq_pkg::*;
#(
  parameter int RECHG_MS      = 20,
  parameter int BLINK_HALF_MS = 500,
  parameter int PULSE_CYC     = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       en_bit,
  input  logic       en_n,
  input  logic       temp_ok,
  input  logic       fault,
  input  logic       stat_off,
  input  logic       bat_pre,
  input  logic       cur_term,
  input  logic       bat_rechg,
  input  logic       at_vreg,
  output logic [2:0] phase,
  output logic       stat_n,
  output logic       int_n
);
  phase_e phase_q;
  logic   phase_evt;
  logic   rechg_go;
  logic   allow;
  logic   in_fault;
  logic   blink_lvl;

  assign allow    = en_bit && !en_n && temp_ok;
  assign in_fault = (phase_q == PH_FAULT);

  chg_fsm #(.RECHG_MS(RECHG_MS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_ms),
    .allow     (allow),
    .fault     (fault),
    .bat_pre   (bat_pre),
    .cur_term  (cur_term),
    .at_vreg   (at_vreg),
    .bat_rechg (bat_rechg),
    .phase_q   (phase_q),
    .phase_evt (phase_evt),
    .rechg_go  (rechg_go)
  );

  chg_blink #(.HALF_MS(BLINK_HALF_MS)) u_blink (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .active (in_fault),
    .level  (blink_lvl)
  );

  chg_intp #(.PULSE_CYC(PULSE_CYC)) u_intp (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (phase_evt),
    .pulse_n (int_n)
  );

  assign phase  = phase_q;
  assign stat_n = stat_off | (in_fault ? blink_lvl : ~is_charging(phase_q));
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_bit,
  input logic       en_n,
  input logic       fault,
  input logic       stat_off,
  input logic [2:0] phase,
  input logic       stat_n,
  input logic       int_n,
  input logic       rechg_go
);
  a_r7_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (phase == 3'd5));

  a_r2_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && (!en_bit || en_n)) |=> (phase == 3'd0));

  a_r5_no_term_from_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |=> (phase != 3'd4));

  a_r6_leave_done_after_deglitch: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(phase) == 3'd4) && (phase == 3'd1 || phase == 3'd2)) |-> $past(rechg_go));

  a_r11_muted_status: assert property (@(posedge clk) disable iff (!rst_n)
    stat_off |-> stat_n);

  a_r9_low_while_charging: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_off && (phase == 3'd1 || phase == 3'd2 || phase == 3'd3)) |-> !stat_n);

  a_r12_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> !int_n);
endmodule

bind chg_seq_top chg_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_bit   (en_bit),
  .en_n     (en_n),
  .fault    (fault),
  .stat_off (stat_off),
  .phase    (phase),
  .stat_n   (stat_n),
  .int_n    (int_n),
  .rechg_go (rechg_go)
);

// File: tb/sim_chg_seq_top.sv
module sim_chg_seq_top;
  localparam int RM = 4;
  localparam int BH = 3;
  localparam int PC = 10;
  localparam int TD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic en_bit = 1'b0, en_n = 1'b1, temp_ok = 1'b1, fault = 1'b0, stat_off = 1'b0;
  logic bat_pre = 1'b0, cur_term = 1'b0, bat_rechg = 1'b0, at_vreg = 1'b0;
  logic [2:0] phase;
  logic stat_n, int_n;

  always #5 clk = ~clk;

  chg_seq_top #(.RECHG_MS(RM), .BLINK_HALF_MS(BH), .PULSE_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick), .en_bit(en_bit), .en_n(en_n),
    .temp_ok(temp_ok), .fault(fault), .stat_off(stat_off), .bat_pre(bat_pre),
    .cur_term(cur_term), .bat_rechg(bat_rechg), .at_vreg(at_vreg),
    .phase(phase), .stat_n(stat_n), .int_n(int_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R1";

  // Reference state kept by the bench.
  logic [2:0] m_ph = 3'd0;
  int m_rc = 0, m_bc = 0, m_ic = 0;
  logic m_bl = 1'b0;

  function automatic logic [2:0] entry(logic low);
    return low ? 3'd1 : 3'd2;
  endfunction

  function automatic logic [2:0] f_next(logic [2:0] cur, logic ok, logic flt,
      logic pre, logic vreg, logic term, logic go);
    if (flt) return 3'd5;
    if (!ok) return 3'd0;
    case (cur)
      3'd0, 3'd1: return entry(pre);
      3'd2: return vreg ? 3'd3 : 3'd2;
      3'd3: return term ? 3'd4 : 3'd3;
      3'd4: return go ? entry(pre) : 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic f_stat(logic [2:0] ph, logic bl, logic off);
    if (off) return 1'b1;
    if (ph == 3'd5) return bl;
    return !(ph >= 3'd1 && ph <= 3'd3);
  endfunction

  always @(posedge clk) begin : model
    logic [2:0] nph;
    logic go;
    if (!rst_n) begin
      m_ph = 3'd0; m_rc = 0; m_bc = 0; m_ic = 0; m_bl = 1'b0;
    end else begin
      go  = (m_ph == 3'd4) && bat_rechg && tick && (m_rc == RM - 1);
      nph = f_next(m_ph, en_bit && !en_n && temp_ok, fault, bat_pre, at_vreg, cur_term, go);
      if (m_ph != 3'd4 || !bat_rechg) m_rc = 0;
      else if (tick) m_rc = m_rc + 1;
      if (m_ph != 3'd5) begin
        m_bc = 0; m_bl = 1'b0;
      end else if (tick) begin
        if (m_bc == BH - 1) begin m_bc = 0; m_bl = ~m_bl; end
        else m_bc = m_bc + 1;
      end
      if (nph != m_ph) m_ic = PC;
      else if (m_ic != 0) m_ic = m_ic - 1;
      m_ph = nph;
    end
  end

  task automatic chk(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d (cycle %0d)", t, got, exp, cyc);
    end
  endtask

  task automatic cmp_all();
    string st;
    st = stat_off ? "R11 status muted" : (m_ph == 3'd5 ? "R10 fault blink" : "R9 status");
    chk(tag, phase, m_ph);
    chk(st, stat_n, f_stat(m_ph, m_bl, stat_off));
    chk("R12 interrupt", int_n, (m_ic == 0));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_all();
      cyc++;
      tick = (cyc % TD == 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 reset phase", phase, 0);
    chk("R1 reset stat_n", stat_n, 1);
    chk("R1 reset int_n", int_n, 1);
    rst_n = 1'b1;

    tag = "R2"; en_bit = 1'b1; en_n = 1'b1; run(8);
    en_bit = 1'b0; en_n = 1'b0; run(8);
    chk("R2 single enable stays idle", phase, 0);

    tag = "R3"; en_bit = 1'b1; bat_pre = 1'b1; run(4);
    chk("R3 conditioning", phase, 1);
    bat_pre = 1'b0; run(3);
    chk("R3 to constant current", phase, 2);

    tag = "R5"; cur_term = 1'b1; run(8);
    chk("R5 term ignored in CC", phase, 2);
    cur_term = 1'b0;

    tag = "R4"; at_vreg = 1'b1; run(3);
    chk("R4 constant voltage", phase, 3);
    tag = "R5"; cur_term = 1'b1; run(3);
    chk("R5 done", phase, 4);
    cur_term = 1'b0; at_vreg = 1'b0;

    tag = "R6"; bat_rechg = 1'b1; run(TD * 2); bat_rechg = 1'b0; run(3);
    chk("R6 short dip ignored", phase, 4);
    bat_rechg = 1'b1; run(TD * (RM - 1));
    chk("R6 still deglitching", phase, 4);
    run(TD * 2);
    chk("R6 recharge restart", phase, 2);
    bat_rechg = 1'b0;

    tag = "R7"; fault = 1'b1; run(3);
    chk("R7 fault", phase, 5);
    run(TD * BH * 5);
    stat_off = 1'b1; run(TD * BH * 2);
    chk("R11 muted during fault", stat_n, 1);
    stat_off = 1'b0; fault = 1'b0; run(4);
    chk("R7 requalified", phase, 2);

    tag = "R8"; temp_ok = 1'b0; run(4);
    chk("R8 suspended", phase, 0);
    temp_ok = 1'b1; run(4);
    chk("R8 resumed", phase, 2);

    tag = "R12"; fault = 1'b1; run(2); fault = 1'b0; run(PC + 5);
    chk("R12 pulse over", int_n, 1);

    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) en_bit = ~en_bit;
      if ($urandom % 60 == 0) en_n = ~en_n;
      if ($urandom % 50 == 0) temp_ok = ~temp_ok;
      if ($urandom % 80 == 0) fault = ~fault;
      if ($urandom % 70 == 0) stat_off = ~stat_off;
      if ($urandom % 15 == 0) bat_pre = ~bat_pre;
      if ($urandom % 12 == 0) cur_term = ~cur_term;
      if ($urandom % 10 == 0) bat_rechg = ~bat_rechg;
      if ($urandom % 12 == 0) at_vreg = ~at_vreg;
      run(1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule